// File: doc/BRIEF.md
# Four-Channel 32-bit Interval Timer Bank

The block holds four independent 32-bit interval timers behind a small memory-mapped register bus with combinational reads. Each channel has its own register window: control, command, match value, prescaler and a read-only count. Each channel picks one of several tick sources, optionally divides it further, and counts those ticks. When the count equals the match value, the count restarts from zero and the channel raises a status bit.

All channels report into one shared status register. Each channel has a byte lane in that register, with three bits. Bits are cleared by writing ones. A single interrupt line is high while any status bit is set together with its enable in the owning channel's control register.

Reference clocks are modelled as one-cycle tick-enable inputs in the single system clock domain. A peripheral tick, a second reference tick and an external slow tick are available. Timer software drives the block in a fixed order: write the match value, clear, configure, then enable. A channel that is cleared before its match value has ever been written raises stray status bits, and the block reproduces this behaviour on purpose.

Top module: `tmr_bank`

## Requirements
- R1: Channel k (k = 0..3) occupies a 0x20-byte window at k*0x20 with control at +0x00, command at +0x04, match value at +0x08, prescaler at +0x10 and count at +0x14. The shared status register is at 0x80. Control reads back only bits [14:12], [10:8], [6] and [5:4], with all other bits zero. The prescaler keeps its low 8 bits. Everything reads zero after reset.
- R2: Offsets +0x0C, +0x18 and +0x1C inside a channel window read zero. So does any address above 0x80. Writes to these addresses change no register.
- R3: While a channel is enabled and in interval mode, each counting tick raises the count by one. A tick that arrives while the count equals the match value instead reloads the count to zero and sets status bit 0 of that channel's lane.
- R4: Command bit 0 is a stored enable that reads back. When clear, the count holds. Writing command bit 1 zeroes the count and the divider and prescaler stages. Bit 1 always reads as 0.
- R5: Control bits [10:8] select the tick source: 000 = reference/2, 001 = reference/4, 010 = reference/16, 011 = reference/64, 10x = reference undivided, 11x = external tick.
- R6: Control bit 6 selects the reference: 0 = peripheral tick input, 1 = second reference tick input. Ticks on the unselected input have no effect.
- R7: A prescaler value N makes one counting tick out of every N+1 selected-source ticks. N = 0 adds no division.
- R8: The status lane of channel 0 is bits [26:24], channel 1 is [18:16], channel 2 is [10:8] and channel 3 is [2:0].
- R9: Writing a 1 to a status bit clears it. A 0 leaves it unchanged.
- R10: irq_o is high exactly when some status bit is set and control bit 12, 13 or 14 of the same channel, matching lane bit 0, 1 or 2 respectively, is also set.
- R11: Until a channel's match value has been written for the first time since reset, a clear command sets all three bits of that channel's status lane. Once the match value has been written, a clear command sets none.
- R12: With control bits [5:4] non-zero, the channel does not count even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access select |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading |
| pclk_tick_i | input | 1 | Peripheral reference tick |
| eclk_tick_i | input | 1 | Second reference tick |
| ext1_tick_i | input | 1 | External slow tick |
| irq_o | output | 1 | Combined interrupt |

## Verification
The count is driven with tick trains of set lengths: short of the match value, exactly reaching it, and past it. This separates plain increment, reload-to-zero and the one-time status set. The divide-by-4, 16 and 64 sources and the prescaler are fed multiples and non-multiples of their ratios, so that an off-by-one in any stage shows as a wrong count. Ticks on an unselected input confirm that a source is really ignored. The clear command is tried both before and after the first match-value write, which exposes the stray-status rule. Lane placement is checked on the first and last channel, and irq_o is checked with the enable bit of the set status bit and with the enable bit of a different one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned STRIDE = 32;
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_CMD  = 5'h04;
  localparam logic [4:0] OFS_MTCH = 5'h08;
  localparam logic [4:0] OFS_PRE  = 5'h10;
  localparam logic [4:0] OFS_CNT  = 5'h14;

  typedef struct packed {
    logic [2:0] ien;
    logic [2:0] src;
    logic       ref_sel;
    logic [1:0] mode;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t ctrl_from_word(input logic [31:0] w);
    tmr_ctrl_t c;
    c.ien     = w[14:12];
    c.src     = w[10:8];
    c.ref_sel = w[6];
    c.mode    = w[5:4];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input tmr_ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[14:12] = c.ien;
    w[10:8]  = c.src;
    w[6]     = c.ref_sel;
    w[5:4]   = c.mode;
    return w;
  endfunction

  function automatic logic [5:0] div_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'h01;
      2'd1:    return 6'h03;
      2'd2:    return 6'h0F;
      default: return 6'h3F;
    endcase
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [2:0]       src_i,
  input  logic             ref_sel_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             pclk_tick_i,
  input  logic             eclk_tick_i,
  input  logic             ext1_tick_i,
  output logic             cnt_tick_o
);
  import tmr_pkg::*;

  logic [5:0]       div_q;
  logic [PRE_W-1:0] pre_q;
  logic             ref_tick, div_tick, src_tick, pre_hit;
  logic [5:0]       mask;

  assign ref_tick = ref_sel_i ? eclk_tick_i : pclk_tick_i;
  assign mask     = div_mask(src_i[1:0]);
  assign div_tick = ref_tick && ((div_q & mask) == mask);

  always_comb begin
    unique case (src_i[2:1])
      2'b10:   src_tick = ref_tick;
      2'b11:   src_tick = ext1_tick_i;
      default: src_tick = div_tick;
    endcase
  end

  assign pre_hit    = (pre_q == pre_i);
  assign cnt_tick_o = run_i && src_tick && pre_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      if (run_i && ref_tick) div_q <= div_q + 6'd1;
      if (run_i && src_tick) pre_q <= pre_hit ? '0 : pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_cmd_i,
  input  logic             wr_mtch_i,
  input  logic             wr_pre_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pclk_tick_i,
  input  logic             eclk_tick_i,
  input  logic             ext1_tick_i,
  output tmr_pkg::tmr_ctrl_t ctrl_o,
  output logic             en_o,
  output logic [CW-1:0]    mtch_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CW-1:0]    cnt_o,
  output logic [2:0]       set_o
);
  import tmr_pkg::*;

  tmr_ctrl_t        ctrl_q;
  logic             en_q, mtch_seen_q;
  logic [CW-1:0]    mtch_q, cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             clr, run, cnt_tick, hit;

  assign clr = wr_cmd_i && wdata_i[1];
  assign run = en_q && (ctrl_q.mode == 2'b00);
  assign hit = cnt_tick && (cnt_q == mtch_q);

  tmr_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .clr_i       (clr),
    .src_i       (ctrl_q.src),
    .ref_sel_i   (ctrl_q.ref_sel),
    .pre_i       (pre_q),
    .pclk_tick_i (pclk_tick_i),
    .eclk_tick_i (eclk_tick_i),
    .ext1_tick_i (ext1_tick_i),
    .cnt_tick_o  (cnt_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      en_q        <= 1'b0;
      mtch_q      <= '0;
      mtch_seen_q <= 1'b0;
      pre_q       <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= ctrl_from_word(32'(wdata_i));
      if (wr_cmd_i)  en_q   <= wdata_i[0];
      if (wr_mtch_i) begin
        mtch_q      <= wdata_i[CW-1:0];
        mtch_seen_q <= 1'b1;
      end
      if (wr_pre_i)  pre_q  <= wdata_i[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (hit)      cnt_q <= '0;
    else if (cnt_tick) cnt_q <= cnt_q + CW'(1);
  end

  // stray status on a clear issued before the first match-value write
  always_comb begin
    set_o    = '0;
    set_o[0] = hit;
    if (clr && !mtch_seen_q) set_o = 3'b111;
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = en_q;
  assign mtch_o = mtch_q;
  assign pre_o  = pre_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          pclk_tick_i,
  input  logic          eclk_tick_i,
  input  logic          ext1_tick_i,
  output logic          irq_o
);
  import tmr_pkg::*;

  localparam int unsigned SW     = NCH * 8;
  localparam int unsigned CIW    = AW - 5;
  localparam int unsigned STAT_A = NCH * STRIDE;

  tmr_ctrl_t        ctrl_a [NCH];
  logic             en_a   [NCH];
  logic [CW-1:0]    mtch_a [NCH];
  logic [PRE_W-1:0] pre_a  [NCH];
  logic [CW-1:0]    cnt_a  [NCH];
  logic [2:0]       set_a  [NCH];

  logic [SW-1:0]     stat_q, set_vec, en_vec, w1c;
  logic [NCH*CW-1:0] cnt_flat;
  logic [CIW-1:0]    ch_idx;
  logic [4:0]        ofs;
  logic              in_ch, wr_acc, stat_hit;

  assign ch_idx   = addr_i[AW-1:5];
  assign ofs      = addr_i[4:0];
  assign in_ch    = (addr_i < AW'(STAT_A));
  assign wr_acc   = sel_i && wr_i;
  assign stat_hit = (addr_i == AW'(STAT_A));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit_k;
    assign hit_k = wr_acc && in_ch && (ch_idx == CIW'(k));

    tmr_channel #(.DW(DW), .CW(CW), .PRE_W(PRE_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ctrl_i   (hit_k && ofs == OFS_CTRL),
      .wr_cmd_i    (hit_k && ofs == OFS_CMD),
      .wr_mtch_i   (hit_k && ofs == OFS_MTCH),
      .wr_pre_i    (hit_k && ofs == OFS_PRE),
      .wdata_i     (wdata_i),
      .pclk_tick_i (pclk_tick_i),
      .eclk_tick_i (eclk_tick_i),
      .ext1_tick_i (ext1_tick_i),
      .ctrl_o      (ctrl_a[k]),
      .en_o        (en_a[k]),
      .mtch_o      (mtch_a[k]),
      .pre_o       (pre_a[k]),
      .cnt_o       (cnt_a[k]),
      .set_o       (set_a[k])
    );
  end

  // lane of channel k starts at bit (NCH-1-k)*8
  always_comb begin
    set_vec  = '0;
    en_vec   = '0;
    cnt_flat = '0;
    for (int k = 0; k < NCH; k++) begin
      set_vec[(NCH-1-k)*8 +: 3] = set_a[k];
      en_vec[(NCH-1-k)*8 +: 3]  = ctrl_a[k].ien;
      cnt_flat[k*CW +: CW]      = cnt_a[k];
    end
  end

  assign w1c = (wr_acc && stat_hit) ? wdata_i[SW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~w1c) | set_vec;
  end

  assign irq_o = |(stat_q & en_vec);

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if (stat_hit) begin
        rdata_o = DW'(stat_q);
      end else if (in_ch) begin
        for (int k = 0; k < NCH; k++) begin
          if (ch_idx == CIW'(k)) begin
            case (ofs)
              OFS_CTRL: rdata_o = DW'(ctrl_to_word(ctrl_a[k]));
              OFS_CMD:  rdata_o = DW'(en_a[k]);
              OFS_MTCH: rdata_o = DW'(mtch_a[k]);
              OFS_PRE:  rdata_o = DW'(pre_a[k]);
              OFS_CNT:  rdata_o = DW'(cnt_a[k]);
              default:  rdata_o = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              pclk_tick_i,
  input logic              eclk_tick_i,
  input logic              ext1_tick_i,
  input logic              irq_o,
  input logic [NCH*8-1:0]  stat_q,
  input logic [NCH*CW-1:0] cnt_flat
);
  localparam int unsigned SW   = NCH * 8;
  localparam int unsigned STAT = NCH * 32;

  logic any_tick, any_wr, unmapped;
  logic [4:0] o;

  assign any_tick = pclk_tick_i || eclk_tick_i || ext1_tick_i;
  assign any_wr   = sel_i && wr_i;
  assign o        = addr_i[4:0];
  assign unmapped = (int'(addr_i) > STAT) ||
                    ((int'(addr_i) < STAT) && (o == 5'h0C || o == 5'h18 || o == 5'h1C));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && unmapped) |-> (rdata_o == '0)); // R2

  AST_STAT_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q)) != '0) |-> $past(any_tick || any_wr)); // R11

  AST_STAT_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wr && int'(addr_i) == STAT && !any_tick) |=> ((stat_q & $past(wdata_i[SW-1:0])) == '0)); // R9

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_tick || any_wr)); // R10

  for (genvar k = 0; k < NCH; k++) begin : g_c
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_flat[k*CW +: CW] == $past(cnt_flat[k*CW +: CW])) ||
      (cnt_flat[k*CW +: CW] == $past(cnt_flat[k*CW +: CW]) + CW'(1)) ||
      (cnt_flat[k*CW +: CW] == '0)); // R3

    AST_CNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_tick && !any_wr) |=> $stable(cnt_flat[k*CW +: CW])); // R4
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .pclk_tick_i (pclk_tick_i),
  .eclk_tick_i (eclk_tick_i),
  .ext1_tick_i (ext1_tick_i),
  .irq_o       (irq_o),
  .stat_q      (stat_q),
  .cnt_flat    (cnt_flat)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pt = 1'b0, et = 1'b0, xt = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  localparam logic [7:0] ST = 8'h80;

  always #10 clk = ~clk;

  tmr_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pclk_tick_i(pt), .eclk_tick_i(et),
    .ext1_tick_i(xt), .irq_o(irq)
  );

  function automatic logic [7:0] ra(input int ch, input int ofs);
    return 8'(ch * 32 + ofs);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #2 d = rdata;
    #2 sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    brd(a, d);
    check(tag, d, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  // src: 0 peripheral, 1 second reference, 2 external
  task automatic ticks(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (src == 0) pt = 1'b1; else if (src == 1) et = 1'b1; else xt = 1'b1;
      @(negedge clk);
      pt = 1'b0; et = 1'b0; xt = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 reset ctrl", ra(0, 'h00), 32'h0);
    rd_chk("R1 reset count", ra(3, 'h14), 32'h0);
    rd_chk("R1 reset status", ST, 32'h0);
    irq_chk("R10 reset irq", 1'b0);
  endtask

  task automatic t_regs;
    bwr(ra(2, 'h00), 32'hFFFF_FFFF);
    rd_chk("R1 ctrl implemented bits", ra(2, 'h00), 32'h0000_7770);
    bwr(ra(2, 'h00), 32'h0);
    bwr(ra(2, 'h08), 32'hA5A5_1234);
    rd_chk("R1 match readback", ra(2, 'h08), 32'hA5A5_1234);
    bwr(ra(2, 'h10), 32'h0000_01FF);
    rd_chk("R1 prescaler width", ra(2, 'h10), 32'h0000_00FF);
    bwr(ra(2, 'h04), 32'h3);
    rd_chk("R4 cmd reads enable only", ra(2, 'h04), 32'h1);
    bwr(ra(2, 'h04), 32'h0);
    bwr(ra(2, 'h10), 32'h0);
    rd_chk("R11 no stray after match write", ST, 32'h0);
  endtask

  task automatic t_stray;
    bwr(ra(1, 'h04), 32'h2);
    rd_chk("R11 stray status ch1 lane", ST, 32'h0007_0000);
    irq_chk("R10 no irq without enable", 1'b0);
    bwr(ST, 32'h0001_0000);
    rd_chk("R9 w1c single bit", ST, 32'h0006_0000);
    bwr(ST, 32'h0006_0000);
    rd_chk("R9 w1c rest", ST, 32'h0);
    bwr(ra(1, 'h08), 32'd10);
    bwr(ra(1, 'h04), 32'h2);
    rd_chk("R11 clear after match write", ST, 32'h0);
  endtask

  task automatic t_interval;
    bwr(ra(0, 'h08), 32'd4);
    bwr(ra(0, 'h04), 32'h2);
    bwr(ra(0, 'h00), 32'h0000_1400);
    bwr(ra(0, 'h10), 32'h0);
    bwr(ra(0, 'h04), 32'h1);
    ticks(0, 3);
    rd_chk("R3 count below match", ra(0, 'h14), 32'd3);
    rd_chk("R3 no status yet", ST, 32'h0);
    ticks(0, 2);
    rd_chk("R3 reload on match", ra(0, 'h14), 32'd0);
    rd_chk("R8 ch0 lane bit 24", ST, 32'h0100_0000);
    irq_chk("R10 irq with enable", 1'b1);
    ticks(0, 6);
    rd_chk("R3 second period", ra(0, 'h14), 32'd1);
    bwr(ST, 32'h0100_0000);
    irq_chk("R10 irq drops after w1c", 1'b0);
  endtask

  task automatic t_enable;
    bwr(ra(0, 'h04), 32'h0);
    ticks(0, 3);
    rd_chk("R4 disabled holds", ra(0, 'h14), 32'd1);
    bwr(ra(0, 'h04), 32'h2);
    rd_chk("R4 clear zeroes count", ra(0, 'h14), 32'd0);
  endtask

  task automatic t_divider;
    bwr(ra(2, 'h08), 32'd1000);
    bwr(ra(2, 'h00), 32'h0000_0140);
    bwr(ra(2, 'h04), 32'h3);
    ticks(0, 5);
    rd_chk("R6 unselected reference ignored", ra(2, 'h14), 32'd0);
    ticks(1, 8);
    rd_chk("R5 div4 eight ticks", ra(2, 'h14), 32'd2);
    ticks(1, 3);
    rd_chk("R5 div4 partial", ra(2, 'h14), 32'd2);
    ticks(1, 1);
    rd_chk("R5 div4 completes", ra(2, 'h14), 32'd3);
    bwr(ra(2, 'h00), 32'h0000_0240);
    bwr(ra(2, 'h04), 32'h3);
    ticks(1, 31);
    rd_chk("R5 div16 partial", ra(2, 'h14), 32'd1);
    ticks(1, 1);
    rd_chk("R5 div16", ra(2, 'h14), 32'd2);
    bwr(ra(2, 'h00), 32'h0000_0340);
    bwr(ra(2, 'h04), 32'h3);
    ticks(1, 128);
    rd_chk("R5 div64", ra(2, 'h14), 32'd2);
    bwr(ra(2, 'h00), 32'h0000_0000);
    bwr(ra(2, 'h04), 32'h3);
    ticks(0, 6);
    rd_chk("R5 div2 peripheral", ra(2, 'h14), 32'd3);
    bwr(ra(2, 'h04), 32'h0);
  endtask

  task automatic t_prescale;
    bwr(ra(3, 'h08), 32'd1000);
    bwr(ra(3, 'h00), 32'h0000_0500);
    bwr(ra(3, 'h10), 32'd2);
    bwr(ra(3, 'h04), 32'h3);
    ticks(0, 9);
    rd_chk("R7 prescale 3", ra(3, 'h14), 32'd3);
    ticks(0, 2);
    rd_chk("R7 prescale partial", ra(3, 'h14), 32'd3);
    ticks(0, 1);
    rd_chk("R7 prescale completes", ra(3, 'h14), 32'd4);
  endtask

  task automatic t_ext;
    bwr(ra(3, 'h10), 32'd0);
    bwr(ra(3, 'h00), 32'h0000_0600);
    bwr(ra(3, 'h04), 32'h3);
    ticks(0, 4);
    rd_chk("R5 ext ignores reference", ra(3, 'h14), 32'd0);
    ticks(2, 5);
    rd_chk("R5 ext tick counts", ra(3, 'h14), 32'd5);
  endtask

  task automatic t_lane3;
    bwr(ra(3, 'h08), 32'd2);
    bwr(ra(3, 'h00), 32'h0000_1700);
    bwr(ra(3, 'h04), 32'h3);
    ticks(2, 3);
    rd_chk("R8 ch3 lane bit 0", ST, 32'h0000_0001);
    irq_chk("R10 ch3 irq", 1'b1);
    bwr(ra(3, 'h00), 32'h0000_2700);
    irq_chk("R10 other enable no irq", 1'b0);
    bwr(ST, 32'h0000_0001);
    rd_chk("R9 ch3 cleared", ST, 32'h0);
  endtask

  task automatic t_mode;
    bwr(ra(3, 'h00), 32'h0000_0610);
    bwr(ra(3, 'h04), 32'h3);
    ticks(2, 4);
    rd_chk("R12 mode 1 holds", ra(3, 'h14), 32'd0);
    bwr(ra(3, 'h00), 32'h0000_0600);
    ticks(2, 2);
    rd_chk("R12 mode 0 counts", ra(3, 'h14), 32'd2);
  endtask

  task automatic t_unmapped;
    bwr(ra(0, 'h0C), 32'hFFFF_FFFF);
    bwr(ra(0, 'h18), 32'hFFFF_FFFF);
    bwr(ra(1, 'h1C), 32'hFFFF_FFFF);
    bwr(8'h84, 32'hFFFF_FFFF);
    rd_chk("R2 read 0x0C", ra(0, 'h0C), 32'h0);
    rd_chk("R2 read 0x18", ra(0, 'h18), 32'h0);
    rd_chk("R2 read 0x3C", ra(1, 'h1C), 32'h0);
    rd_chk("R2 read 0x84", 8'h84, 32'h0);
    rd_chk("R2 match untouched", ra(0, 'h08), 32'd4);
    rd_chk("R2 prescaler untouched", ra(0, 'h10), 32'd0);
    rd_chk("R2 status untouched", ST, 32'h0);
    rd_chk("R2 ch1 ctrl untouched", ra(1, 'h00), 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_stray();
    t_interval();
    t_enable();
    t_divider();
    t_prescale();
    t_ext();
    t_lane3();
    t_mode();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule